// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus. It fronts a 256-byte storage array that is modelled in flip-flops. A fast system clock samples the bus clock and data lines. The block detects bus framing and decodes a 7-bit device address followed by a read/write bit. It supports these transfers: byte write, page write of up to 16 bytes, current-address read, random read and sequential read. The data line is driven as an open-drain pull-down enable. Writes are first collected in a page buffer. They reach the array only after a programming interval, which is counted in system clocks. While that interval runs, the block does not acknowledge its address, so a host can poll for completion. A write-protect input and a supervisor reset input also act on the bus traffic.

The sequencer has eight states:
- `ST_IDLE`: waits for a START.
- `ST_DEV`: shifts in the address byte.
- `ST_PTR`: shifts in the pointer byte.
- `ST_WDATA`: shifts in data bytes.
- `ST_ACK`: drives the acknowledge slot.
- `ST_RDATA`: shifts out a byte.
- `ST_RACK`: samples the host acknowledge.
- `ST_WAIT`: stays off the bus until the next START or STOP.

The transitions are as follows:
- START leads from any state to `ST_DEV`.
- STOP or the reset input leads from any state to `ST_IDLE`.
- `ST_DEV` goes to `ST_ACK` when the address matches and no programming is running; otherwise it goes to `ST_WAIT`.
- `ST_PTR` goes to `ST_ACK`.
- `ST_WDATA` goes to `ST_ACK`, or to `ST_WAIT` under write protect.
- `ST_ACK` goes on to `ST_PTR`, `ST_WDATA` or `ST_RDATA`.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes back to `ST_RDATA` on a host ACK, or to `ST_WAIT` on a NACK.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, the data line is released, the read/write pointer is 0, every array byte is 0, and no programming interval is running, so a matching address is acknowledged at once.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in mid-transfer begins a new address phase (repeated START).
- R3: The first byte after START carries the 7-bit device address (default 7'h50) in bits 7..1 and R/W in bit 0, where 1 means read. The slave pulls SDA low in the ninth clock only on a match. On a mismatch it releases the line until the next START or STOP.
- R4: In a write, the byte after the address loads the 8-bit pointer. Each following data byte is acknowledged and stored at the pointer. After each byte, bits 3..0 of the pointer increment and bits 7..4 stay fixed.
- R5: Data bytes past the 16th wrap within the page and overwrite earlier bytes of the same transfer.
- R6: Buffered bytes are programmed together only after a STOP. The array changes when PROG_CYCLES clocks have elapsed. A STOP that follows no data byte starts no programming.
- R7: During programming, the device address is not acknowledged. After programming ends it is acknowledged again.
- R8: A current-address read returns the byte at the pointer, which is the last accessed address + 1. After a write, that address follows the in-page wrap.
- R9: A random read (a pointer-only write header, a repeated START, then a read header) returns the byte at the new pointer. A sequential read keeps returning bytes while the host ACKs, with all 8 pointer bits incrementing, so 0xFF is followed by 0x00.
- R10: When the host NACKs a read byte, the slave releases SDA and ignores clocks until the next START or STOP.
- R11: With wp_i high, the address and pointer bytes are acknowledged, the first data byte is NACKed, and nothing is programmed.
- R12: While hold_i is high, any transfer is aborted and buffered bytes are dropped. New transfers are not acknowledged. A programming interval already running still completes.
- R13: The data-line pull-down only turns on after a sampled SCL falling edge, and it stays constant while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| wp_i | input | 1 | Write protect, high blocks programming |
| hold_i | input | 1 | Supervisor reset active, aborts and blocks transfers |
| sda_pull_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Writes are tried in three forms:
- a single byte;
- an 18-byte page burst that starts two bytes before the page end, which separates in-page wrap and overwrite from a plain linear increment;
- a one-byte write at 0xFF, which sets up the wrap of a sequential read from 0xFF to 0x00 on the full pointer.

Reads are tried in three forms: a pointer-only random read, a current-address read after a wrapped page write, and a host-NACKed read followed by idle clocks. Together they show that the pointer follows the correct rule in each mode. Address polling is done right after each STOP. It tells a real programming interval apart from the absence of one after pointer-only, write-protected and aborted transfers. Every bus bit the slave drives is compared with a behavioural memory model.

// File: rtl/ee_pkg.sv
package ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } ee_state_e;
endpackage

// File: rtl/ee_bus_sync.sv
// Synchronises SCL/SDA and derives edge and framing strobes.
module ee_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign sda_o    = sda_s;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_o  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_prog_timer.sv
// Counts the programming interval; done pulses on the last cycle.
module ee_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= TW'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == TW'(1));
endmodule

// File: rtl/ee_store.sv
// Storage array plus a separate page buffer merged on programming end.
module ee_store #(
    parameter int DEPTH = 256,
    parameter int PAGE  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  buf_we,
    input  logic [$clog2(PAGE)-1:0]               buf_idx,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] buf_tag,
    input  logic [7:0]                            buf_data,
    input  logic                                  buf_clr,
    input  logic                                  merge,
    input  logic [$clog2(DEPTH)-1:0]              rd_addr,
    output logic [7:0]                            rd_data,
    output logic                                  pending
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam int TW = AW - PW;

    logic [7:0]      arr  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pval;
    logic [TW-1:0]   tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
            for (int j = 0; j < PAGE; j++)  pbuf[j] <= '0;
            pval <= '0;
            tag  <= '0;
        end else if (merge) begin
            for (int j = 0; j < PAGE; j++)
                if (pval[j]) arr[{tag, PW'(j)}] <= pbuf[j];
            pval <= '0;
        end else if (buf_clr) begin
            pval <= '0;
        end else if (buf_we) begin
            pbuf[buf_idx] <= buf_data;
            pval[buf_idx] <= 1'b1;
            tag           <= buf_tag;
        end
    end

    assign rd_data = arr[rd_addr];
    assign pending = |pval;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import ee_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter int         PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic hold_i,
    output logic sda_pull_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    ee_state_e state, state_n, nxt;
    logic sda_s, scl_rise, scl_fall, start, stop;
    logic busy, done, pending, commit, buf_we, buf_clr;
    logic [7:0]    shreg, byte_in, rd_data;
    logic [2:0]    bit_cnt;
    logic [AW-1:0] ptr;
    logic          ph, last_bit;

    ee_bus_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_o(start), .stop_o(stop)
    );

    ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy), .done(done)
    );

    ee_store #(.DEPTH(MEM_BYTES), .PAGE(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(ptr[PW-1:0]),
        .buf_tag(ptr[AW-1:PW]), .buf_data(byte_in), .buf_clr(buf_clr),
        .merge(done), .rd_addr(ptr), .rd_data(rd_data), .pending(pending)
    );

    assign byte_in  = {shreg[6:0], sda_s};
    assign last_bit = scl_rise && (bit_cnt == 3'd7);

    // Next-state and control strobes
    always_comb begin
        state_n = state;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        commit  = 1'b0;
        if (hold_i) begin
            state_n = ST_IDLE;
            buf_clr = !busy;
        end else if (start) begin
            state_n = ST_DEV;
            buf_clr = !busy;
        end else if (stop) begin
            state_n = ST_IDLE;
            commit  = pending && !busy;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: ;
                ST_DEV:
                    if (last_bit)
                        state_n = (byte_in[7:1] == DEV_ADDR && !busy) ? ST_ACK : ST_WAIT;
                ST_PTR:
                    if (last_bit) state_n = ST_ACK;
                ST_WDATA:
                    if (last_bit) begin
                        state_n = wp_i ? ST_WAIT : ST_ACK;
                        buf_we  = !wp_i;
                    end
                ST_ACK:
                    if (scl_fall && ph) state_n = nxt;
                ST_RDATA:
                    if (last_bit) state_n = ST_RACK;
                ST_RACK:
                    if (scl_rise && sda_s)   state_n = ST_WAIT;
                    else if (scl_fall && ph) state_n = ST_RDATA;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            ptr        <= '0;
            ph         <= 1'b0;
            nxt        <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else if (hold_i || start || stop) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            ph         <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV, ST_PTR, ST_WDATA:
                    if (scl_rise) begin
                        shreg   <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            ph <= 1'b0;
                            if (state == ST_DEV) begin
                                nxt <= byte_in[0] ? ST_RDATA : ST_PTR;
                            end else if (state == ST_PTR) begin
                                ptr <= byte_in[AW-1:0];
                                nxt <= ST_WDATA;
                            end else if (!wp_i) begin
                                ptr[PW-1:0] <= ptr[PW-1:0] + PW'(1);
                                nxt         <= ST_WDATA;
                            end
                        end
                    end
                ST_ACK:
                    if (scl_fall) begin
                        if (!ph) begin
                            sda_pull_o <= 1'b1;
                            ph         <= 1'b1;
                        end else begin
                            ph         <= 1'b0;
                            bit_cnt    <= '0;
                            sda_pull_o <= (nxt == ST_RDATA) ? ~rd_data[7] : 1'b0;
                        end
                    end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            ptr <= ptr + AW'(1);
                            ph  <= 1'b0;
                        end
                    end
                    if (scl_fall && bit_cnt != 3'd0)
                        sda_pull_o <= ~rd_data[3'd7 - bit_cnt];
                end
                ST_RACK:
                    if (scl_fall) begin
                        if (!ph) begin
                            sda_pull_o <= 1'b0;
                            ph         <= 1'b1;
                        end else begin
                            ph         <= 1'b0;
                            bit_cnt    <= '0;
                            sda_pull_o <= ~rd_data[7];
                        end
                    end
                default: sda_pull_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ee_chk.sv
module ee_chk
    import ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input ee_state_e state,
    input logic      busy,
    input logic      hold,
    input logic      wp,
    input logic      scl_fall,
    input logic      pull,
    input logic      commit
);
    // R13
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> $past(scl_fall));

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && busy) |=> state != ST_ACK);

    // R12
    hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == ST_IDLE && !pull));

    // R11
    wp_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && wp) |=> state != ST_ACK);

    // R6
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R12
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) && hold |-> !$rose(busy));
endmodule

bind eeprom_i2c_slave ee_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .busy(busy), .hold(hold_i),
    .wp(wp_i), .scl_fall(scl_fall), .pull(sda_pull_o), .commit(commit)
);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int PROG       = 600;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0, hold = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int total = 0, bad = 0, mptr = 0, hi_cnt = 0;
    logic [7:0] model [256];
    logic prev_pull = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_slave #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .wp_i(wp), .hold_i(hold), .sda_pull_o(sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R13: per-clock comparison, pull must hold while SCL is settled high
    always @(negedge clk) begin
        if (rst_n && scl && !hold) begin
            hi_cnt++;
            if (hi_cnt > 3) chk(sda_pull == prev_pull, "R13", sda_pull, prev_pull);
        end else hi_cnt = 0;
        prev_pull = sda_pull;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(2*Q);
    endtask

    task automatic bit_tx(input bit b, output bit s);
        sda_m = b; wclk(Q); scl = 1'b1; wclk(Q);
        s = sda_line; wclk(Q); scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) bit_tx(b[i], s);
        bit_tx(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        bit s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_tx(1'b1, s);
            d = {d[6:0], s};
        end
        bit_tx(!mack, s);
    endtask

    task automatic poll(input bit exp_ack, input string req);
        bit a;
        i2c_start();
        send_byte(8'hA0, a);
        i2c_stop();
        chk(a == exp_ack, req, a, exp_ack);
    endtask

    // write without programming wait; model updated by caller
    task automatic write_raw(input logic [7:0] addr, input logic [7:0] d[$], input string req);
        bit a;
        i2c_start();
        send_byte(8'hA0, a); chk(a, "R3", a, 1);
        send_byte(addr, a);  chk(a, "R4", a, 1);
        foreach (d[i]) begin
            send_byte(d[i], a); chk(a, req, a, 1);
        end
        i2c_stop();
    endtask

    task automatic model_write(input logic [7:0] addr, input logic [7:0] d[$]);
        int lo = addr & 15;
        foreach (d[i]) begin
            model[(addr & 8'hF0) | lo] = d[i];
            lo = (lo + 1) & 15;
        end
        mptr = (addr & 8'hF0) | lo;
    endtask

    task automatic write_full(input logic [7:0] addr, input logic [7:0] d[$], input string req);
        write_raw(addr, d, req);
        model_write(addr, d);
        poll(1'b0, "R7");
        wclk(PROG + 20);
        poll(1'b1, "R7");
    endtask

    task automatic rand_read(input logic [7:0] addr, input int n, input string req);
        bit a;
        logic [7:0] d;
        i2c_start();
        send_byte(8'hA0, a); chk(a, "R3", a, 1);
        send_byte(addr, a);  chk(a, "R9", a, 1);
        i2c_start();
        send_byte(8'hA1, a); chk(a, "R2", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model[(addr + i) & 255], req, d, model[(addr + i) & 255]);
        end
        i2c_stop();
        mptr = (addr + n) & 255;
    endtask

    task automatic cur_read(input string req);
        bit a;
        logic [7:0] d;
        i2c_start();
        send_byte(8'hA1, a); chk(a, "R3", a, 1);
        recv_byte(1'b0, d);
        chk(d == model[mptr], req, d, model[mptr]);
        i2c_stop();
        mptr = (mptr + 1) & 255;
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        logic [7:0] q[$];
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wclk(5); rst_n = 1'b1; wclk(5);

        // R1: reset state
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);
        poll(1'b1, "R1");
        cur_read("R1");

        // R3: wrong device address, then silence for the rest of the frame
        i2c_start();
        send_byte(8'hA2, a); chk(!a, "R3", a, 0);
        send_byte(8'h00, a); chk(!a, "R3", a, 0);
        i2c_stop();

        // R6/R7: byte write with ACK polling
        q = '{8'hA7};
        write_full(8'h25, q, "R4");
        rand_read(8'h25, 1, "R9");
        poll(1'b1, "R6");          // pointer-only write above started no cycle
        cur_read("R8");

        // R4: neighbour page untouched before page write
        rand_read(8'h40, 1, "R4");

        // R5: 18-byte burst from 0x3E wraps inside page 0x30
        q = {};
        for (int i = 0; i < 18; i++) q.push_back(8'(8'h10 + i));
        write_full(8'h3E, q, "R5");
        cur_read("R8");
        rand_read(8'h30, 16, "R5");
        rand_read(8'h40, 1, "R4");

        // R9: sequential read across 0xFF -> 0x00
        q = '{8'h5A};
        write_full(8'hFF, q, "R6");
        rand_read(8'hFE, 3, "R9");

        // R10: host NACK, slave stays off the bus
        i2c_start();
        send_byte(8'hA1, a); chk(a, "R3", a, 1);
        recv_byte(1'b0, d);
        send_byte(8'h00, a); chk(!a, "R10", a, 0);
        i2c_stop();
        poll(1'b1, "R10");

        // R11: write protect
        wp = 1'b1;
        i2c_start();
        send_byte(8'hA0, a); chk(a, "R11", a, 1);
        send_byte(8'h60, a); chk(a, "R11", a, 1);
        send_byte(8'h33, a); chk(!a, "R11", a, 0);
        i2c_stop();
        wp = 1'b0;
        poll(1'b1, "R11");
        rand_read(8'h60, 1, "R11");

        // R12: abort in mid-write
        i2c_start();
        send_byte(8'hA0, a);
        send_byte(8'h70, a);
        send_byte(8'h44, a); chk(a, "R12", a, 1);
        hold = 1'b1; wclk(4);
        chk(sda_pull == 1'b0, "R12", sda_pull, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'hA0, a); chk(!a, "R12", a, 0);
        i2c_stop();
        hold = 1'b0;
        poll(1'b1, "R12");
        rand_read(8'h70, 1, "R12");

        // R12: running programming completes under hold
        q = '{8'h99};
        write_raw(8'h80, q, "R4");
        model_write(8'h80, q);
        hold = 1'b1; wclk(PROG + 20); hold = 1'b0;
        poll(1'b1, "R12");
        rand_read(8'h80, 1, "R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule